// File: doc/BRIEF.md
# Source-Routed Hop Header Stripper

This block sits at the receive side of one switch port in a network where the sender lays out the whole path in advance. Each packet starts with a string of routing bytes, one for every switch the packet will cross. The stage looks only at the byte at the front of that string. It checks the byte's parity and turns its index field into an output-port number for the crossbar. It then drops the byte and passes the rest of the packet downstream, so the next switch finds its own byte at the front.

A corrupted routing byte is never acted on. When the parity check fails, or the index names a port that does not exist, the stage discards the whole packet. It then raises a one-cycle request that asks the upstream link to send the packet again. A packet that holds nothing but a routing byte is also thrown away, but no retransmission is requested for it.

Both streams use a valid/ready handshake with start-of-packet and end-of-packet markers. The output side has a single register stage that honours backpressure.

Top module: `rsh_strip_stage`

## Requirements
- R1: After reset, out_valid, sel_valid, retry_req and malformed are low, and in_ready is high.
- R2: When a routing byte is accepted that has good parity, a valid index and is not the last byte, sel_valid is high for exactly one cycle, in the cycle after the byte is accepted. sel_port equals the low $clog2(NUM_PORTS) bits of that byte.
- R3: The routing byte never appears on the output. The remaining bytes come out in order, with out_sop on the first of them and out_eop on the last.
- R4: Parity is odd. The XOR of all 8 bits of a routing byte must be 1, with bit 7 as the parity bit. A routing byte that fails this check gives a one-cycle retry_req in the cycle after it is accepted, and no sel_valid.
- R5: After a rejected routing byte, every byte up to and including the one marked end-of-packet is accepted with in_ready high, and none of them reaches the output.
- R6: A routing byte whose index field (bits 6:0) is NUM_PORTS or more is handled exactly like a parity failure (R4, R5).
- R7: A packet of one byte, where the routing byte also carries eop, gives a one-cycle malformed pulse and no retry_req, no sel_valid and no output. This holds whatever the parity of the byte.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data, out_sop and out_eop stay stable. During forwarding, in_ready is low for that time.
- R9: A byte accepted while the stage waits for a routing byte but without in_sop is discarded and produces no output and no pulse.
- R10: In any cycle, at most one of sel_valid, retry_req and malformed is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Stage can take an input byte |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Input byte is the first of a packet |
| in_eop | input | 1 | Input byte is the last of a packet |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can take the output byte |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | Output byte is the first after stripping |
| out_eop | output | 1 | Output byte is the last of the packet |
| sel_valid | output | 1 | One-cycle pulse: sel_port holds a decoded port |
| sel_port | output | $clog2(NUM_PORTS) | Decoded output-port number |
| retry_req | output | 1 | One-cycle link-level retransmission request |
| malformed | output | 1 | One-cycle pulse: a one-byte packet was dropped |

## Verification
The assertions check four things on every cycle. The output byte and its markers are held while the output is stalled. The input is blocked during a stall while forwarding. The three event pulses never overlap and each lasts one cycle. The output stays empty while the stage is rejecting or waiting for a routing byte. Other behaviour can only be shown by the bench's scenarios, because it depends on whole packets:
- the decoded port number,
- that the header is removed and the payload bytes keep their order,
- where the new start marker lands,
- that a stray byte or a one-byte packet is discarded without a retry request.

// File: rtl/rsh_pkg.sv
package rsh_pkg;
   localparam int RB_W = 8;
   localparam int IDX_W = RB_W - 1;
   typedef enum logic [1:0] {
      ST_HEAD,
      ST_FWD,
      ST_DROP
   } rsh_state_e;
endpackage

// File: rtl/rsh_route_check.sv
module rsh_route_check #(
   parameter int NUM_PORTS = 8,
   parameter bit ODD_PARITY = 1'b1,
   localparam int SEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic [rsh_pkg::RB_W-1:0] rbyte,
   output logic                     par_ok,
   output logic                     port_ok,
   output logic [SEL_W-1:0]         port
);
   import rsh_pkg::*;

   generate
      if (ODD_PARITY) begin : g_odd
         assign par_ok = ^rbyte;
      end else begin : g_even
         assign par_ok = ~^rbyte;
      end

      if (NUM_PORTS == (1 << IDX_W)) begin : g_full
         assign port_ok = 1'b1;
      end else begin : g_range
         assign port_ok = (rbyte[IDX_W-1:0] < IDX_W'(NUM_PORTS));
      end
   endgenerate

   assign port = rbyte[SEL_W-1:0];
endmodule

// File: rtl/rsh_out_reg.sv
module rsh_out_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] ld_data,
   input  logic         ld_sop,
   input  logic         ld_eop,
   input  logic         out_ready,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   output logic         out_sop,
   output logic         out_eop,
   output logic         free
);
   assign free = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_sop   <= 1'b0;
         out_eop   <= 1'b0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_data  <= ld_data;
         out_sop   <= ld_sop;
         out_eop   <= ld_eop;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R8: a stalled byte keeps its value and markers
   assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)
                                  && $stable(out_sop) && $stable(out_eop));
endmodule

// File: rtl/rsh_strip_stage.sv
module rsh_strip_stage #(
   parameter int NUM_PORTS = 8,
   parameter bit ODD_PARITY = 1'b1,
   localparam int SEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [rsh_pkg::RB_W-1:0] in_data,
   input  logic                     in_sop,
   input  logic                     in_eop,
   output logic                     out_valid,
   input  logic                     out_ready,
   output logic [rsh_pkg::RB_W-1:0] out_data,
   output logic                     out_sop,
   output logic                     out_eop,
   output logic                     sel_valid,
   output logic [SEL_W-1:0]         sel_port,
   output logic                     retry_req,
   output logic                     malformed
);
   import rsh_pkg::*;

   generate
      if (NUM_PORTS < 2 || NUM_PORTS > (1 << IDX_W)) begin : g_bad_ports
         $error("rsh_strip_stage: NUM_PORTS must lie in 2..128");
      end
   endgenerate

   rsh_state_e       state_q;
   logic             first_q;
   logic             par_ok, port_ok, free, accept, load;
   logic [SEL_W-1:0] dec_port;

   rsh_route_check #(.NUM_PORTS(NUM_PORTS), .ODD_PARITY(ODD_PARITY)) u_chk (
      .rbyte(in_data), .par_ok(par_ok), .port_ok(port_ok), .port(dec_port));

   rsh_out_reg #(.W(RB_W)) u_oreg (
      .clk(clk), .rst_n(rst_n), .load(load), .ld_data(in_data),
      .ld_sop(first_q), .ld_eop(in_eop), .out_ready(out_ready),
      .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
      .out_eop(out_eop), .free(free));

   assign in_ready = (state_q == ST_FWD) ? free : 1'b1;
   assign accept   = in_valid && in_ready;
   assign load     = accept && (state_q == ST_FWD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_HEAD;
         first_q   <= 1'b0;
         sel_valid <= 1'b0;
         sel_port  <= '0;
         retry_req <= 1'b0;
         malformed <= 1'b0;
      end else begin
         sel_valid <= 1'b0;
         retry_req <= 1'b0;
         malformed <= 1'b0;
         if (accept) begin
            unique case (state_q)
               ST_HEAD: if (in_sop) begin
                  if (in_eop) begin
                     malformed <= 1'b1;
                  end else if (par_ok && port_ok) begin
                     sel_valid <= 1'b1;
                     sel_port  <= dec_port;
                     first_q   <= 1'b1;
                     state_q   <= ST_FWD;
                  end else begin
                     retry_req <= 1'b1;
                     state_q   <= ST_DROP;
                  end
               end
               ST_FWD: begin
                  first_q <= 1'b0;
                  if (in_eop) state_q <= ST_HEAD;
               end
               ST_DROP: if (in_eop) state_q <= ST_HEAD;
               default: state_q <= ST_HEAD;
            endcase
         end
      end
   end

   // R10: event pulses are mutually exclusive
   assert_one_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_valid, retry_req, malformed}));
   // R2: port select lasts one cycle
   assert_sel_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |=> !sel_valid);
   // R4: retry request lasts one cycle and starts a discard
   assert_retry_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      retry_req |-> !$past(retry_req) && state_q == ST_DROP);
   // R5: an empty output stays empty outside forwarding
   assert_drop_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != ST_FWD && !out_valid |=> !out_valid);
   // R8: a stalled output blocks the input while forwarding
   assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_FWD && out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/rsh_strip_stage_test.sv
module rsh_strip_stage_test;
   localparam int NP = 8;
   localparam int SW = $clog2(NP);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, out_ready = 1'b1;
   logic [7:0] in_data = '0;
   logic in_ready, out_valid, out_sop, out_eop, sel_valid, retry_req, malformed;
   logic [7:0] out_data;
   logic [SW-1:0] sel_port;

   always #10 clk = ~clk;

   rsh_strip_stage #(.NUM_PORTS(NP)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_sop(out_sop), .out_eop(out_eop), .sel_valid(sel_valid),
      .sel_port(sel_port), .retry_req(retry_req), .malformed(malformed));

   int n_chk = 0, n_bad = 0;
   int n_sel, n_retry, n_mal, n_out, n_overlap;
   logic [7:0] obuf [16];
   logic osop [16];
   logic oeop [16];
   logic [SW-1:0] last_port;

   // monitor: sample at the falling edge, the transfer completes at the next rise
   always @(negedge clk) if (rst_n) begin
      if (sel_valid) begin n_sel++; last_port = sel_port; end
      if (retry_req) n_retry++;
      if (malformed) n_mal++;
      if (32'(sel_valid) + 32'(retry_req) + 32'(malformed) > 1) n_overlap++;
      if (out_valid && out_ready && n_out < 16) begin
         obuf[n_out] = out_data; osop[n_out] = out_sop; oeop[n_out] = out_eop;
         n_out++;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] hdr(input logic [6:0] idx);
      return {~^idx, idx};
   endfunction

   task automatic clear();
      n_sel = 0; n_retry = 0; n_mal = 0; n_out = 0; n_overlap = 0;
   endtask

   // drive at rise+2, keep until the byte is taken
   task automatic put(input logic [7:0] d, input logic s, input logic e, output int stalls);
      bit ok;
      stalls = 0;
      in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
      forever begin
         #1 ok = in_ready;
         @(posedge clk); #2;
         if (ok) break;
         stalls++;
      end
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
   endtask

   task automatic send(input logic [7:0] h, input logic [7:0] p [], output int stalls);
      int st;
      put(h, 1'b1, (p.size() == 0), st);
      stalls = st;
      foreach (p[i]) begin
         put(p[i], 1'b0, (i == p.size() - 1), st);
         stalls += st;
      end
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      #2;
   endtask

   task automatic t_reset();
      check(!out_valid && !sel_valid && !retry_req && !malformed, "R1 outputs idle",
            int'({out_valid, sel_valid, retry_req, malformed}), 0);
      check(in_ready, "R1 in_ready", int'(in_ready), 1);
   endtask

   task automatic t_good(input logic [6:0] idx, input logic [7:0] p []);
      int st;
      clear();
      send(hdr(idx), p, st);
      settle();
      check(n_sel == 1, "R2 sel pulse count", n_sel, 1);
      check(last_port == idx[SW-1:0], "R2 sel_port", int'(last_port), int'(idx));
      check(n_retry == 0 && n_mal == 0, "R2 no error pulse", n_retry + n_mal, 0);
      check(n_out == p.size(), "R3 byte count", n_out, p.size());
      foreach (p[i]) if (i < n_out) begin
         check(obuf[i] == p[i], "R3 payload byte", int'(obuf[i]), int'(p[i]));
         check(osop[i] == (i == 0), "R3 out_sop", int'(osop[i]), int'(i == 0));
         check(oeop[i] == (i == p.size() - 1), "R3 out_eop", int'(oeop[i]),
               int'(i == p.size() - 1));
      end
      check(n_overlap == 0, "R10 overlap", n_overlap, 0);
   endtask

   task automatic t_reject(input logic [7:0] h, input string req);
      int st;
      logic [7:0] p [] = '{8'h11, 8'h22, 8'h33};
      clear();
      send(h, p, st);
      settle();
      check(n_retry == 1, {req, " retry pulse"}, n_retry, 1);
      check(n_sel == 0 && n_mal == 0, {req, " no sel/malformed"}, n_sel + n_mal, 0);
      check(n_out == 0, "R5 nothing forwarded", n_out, 0);
      check(st == 0, "R5 discard never stalls", st, 0);
   endtask

   task automatic t_malformed(input logic [7:0] h);
      int st;
      clear();
      put(h, 1'b1, 1'b1, st);
      settle();
      check(n_mal == 1, "R7 malformed pulse", n_mal, 1);
      check(n_retry == 0 && n_sel == 0 && n_out == 0, "R7 nothing else",
            n_retry + n_sel + n_out, 0);
   endtask

   task automatic t_stray();
      int st;
      clear();
      put(8'h83, 1'b0, 1'b0, st);
      put(8'h44, 1'b0, 1'b1, st);
      settle();
      check(n_out == 0 && n_sel + n_retry + n_mal == 0, "R9 stray bytes discarded",
            n_out + n_sel + n_retry + n_mal, 0);
      t_good(7'd5, '{8'h66});
   endtask

   task automatic t_backpressure();
      int st;
      logic [7:0] p [] = '{8'hA5, 8'h5A, 8'hC3};
      logic [7:0] held;
      clear();
      @(posedge clk); #2 out_ready = 1'b0;
      fork
         send(hdr(7'd6), p, st);
         begin
            while (!out_valid) begin @(posedge clk); #2; end
            held = out_data;
            repeat (3) begin
               @(negedge clk);
               check(out_valid && out_data == held, "R8 output held",
                     int'(out_data), int'(held));
               check(!in_ready, "R8 input blocked", int'(in_ready), 0);
            end
            @(posedge clk); #2 out_ready = 1'b1;
         end
      join
      settle();
      check(n_out == 3 && obuf[0] == 8'hA5 && obuf[2] == 8'hC3, "R8 order after stall",
            n_out, 3);
      check(held == 8'hA5, "R8 held byte", int'(held), 8'hA5);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(posedge clk);
            #2 rst_n = 1'b1;
            #1 t_reset();
            @(posedge clk); #2;
            t_good(7'd3, '{8'hA1, 8'hB2, 8'hC3});
            t_good(7'd0, '{8'h5A});
            t_good(7'd7, '{8'h01, 8'h02});
            t_good(7'd1, '{8'hF0, 8'h0F});
            t_reject(8'h03, "R4 even parity");
            t_reject(8'h80 | 8'h01 ^ 8'h80, "R4 bad parity bit");
            t_reject(hdr(7'd9), "R6 index too large");
            t_reject(hdr(7'd127), "R6 index max");
            t_malformed(hdr(7'd2));
            t_malformed(8'h02);
            t_stray();
            t_backpressure();
         end
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule